// File: doc/BRIEF.md
# Shared Scaler Lock Arbiter

Two scaler units are shared among a group of media engines: decode engines and enhancement engines. While no one is freezing a unit, each unit hands itself to one requesting engine and keeps it there until that engine drops its request line. Before an engine is reset, software raises that engine's forced-lock control bit. This does not take the unit away from its holder. It freezes the unit's ownership where it stands. A unit that is held stays with its holder, and a unit that is free turns away every new claim until all forced-lock bits on it are cleared.

Each engine sees two status bits. The acknowledge bit tells it that the unit's ownership is now fixed. The usage bit tells it that it is the frozen holder, and so that the unit must be reset along with the engine. Decode engine n belongs to unit n>>1 and enhancement engine n belongs to unit n. An access mask selects which decode engines take part. A per-unit reset input returns a unit to the free state.

Top module: `scl_lock_arbiter`

## Requirements
- R1: After rst_n is released, every acknowledge and usage output is 0 and both units are free.
- R2: Decode engine n (bit n of each dec_* vector) competes only for unit n>>1. Enhancement engine n (bit n of each enh_* vector) competes only for unit n.
- R3: When no forced lock is active on a free unit, a requesting engine is granted that unit at the next clock edge. An owner keeps the unit until its request is low at a clock edge with no freeze, and the unit becomes free at that edge.
- R4: When an enhancement engine and one or more decode engines request the same free, unfrozen unit in one cycle, the enhancement engine wins. Among decode engines, the lower instance wins.
- R5: While any enabled forced-lock bit of a unit is high, a held unit keeps its owner, even if the owner drops its request and other engines request.
- R6: While any enabled forced-lock bit of a unit is high, a free unit stays free and grants no request.
- R7: An engine's acknowledge is 1 exactly one clock after its forced-lock bit is sampled high, and 0 one clock after that bit is sampled low.
- R8: An engine's usage bit is 1 only when its acknowledge is 1 and it owns the unit. At most one usage bit per unit is 1.
- R9: A decode engine whose dec_access_mask bit is 0 never gets an acknowledge, never freezes its unit, and is never granted a unit.
- R10: A high unit_rst[u] frees unit u at the next edge. If a forced lock is still held, the unit stays frozen and free until that forced lock is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_rst | input | NUM_UNITS | Per-unit ownership clear |
| dec_access_mask | input | NUM_UNITS*DEC_PER_UNIT | Decode engines allowed to take part |
| dec_req | input | NUM_UNITS*DEC_PER_UNIT | Decode claim request lines |
| dec_force | input | NUM_UNITS*DEC_PER_UNIT | Decode forced-lock control bits |
| enh_req | input | NUM_UNITS | Enhancement claim request lines |
| enh_force | input | NUM_UNITS | Enhancement forced-lock control bits |
| dec_ack | output | NUM_UNITS*DEC_PER_UNIT | Decode acknowledge bits |
| dec_use | output | NUM_UNITS*DEC_PER_UNIT | Decode usage bits |
| enh_ack | output | NUM_UNITS | Enhancement acknowledge bits |
| enh_use | output | NUM_UNITS | Enhancement usage bits |

## Verification
Ownership is not brought out directly. It shows only through usage bits, one clock after a forced lock is raised. A wrong owner, a missed release or a grant taken during a freeze therefore stays hidden until the next freeze. At that point it shows as a usage bit on the wrong engine, or as no usage bit at all. For this reason the bench freezes each unit after every ownership event that matters, and compares the full acknowledge and usage vectors one clock later. A wrong acknowledge path shows on the very next clock after the forced-lock bit changes.

// File: rtl/scl_lock_pkg.sv
package scl_lock_pkg;
   // Holder class of a scaler unit
   typedef enum logic [1:0] {
      OWN_FREE = 2'd0,
      OWN_ENH  = 2'd1,
      OWN_DEC  = 2'd2
   } own_kind_e;
endpackage

// File: rtl/scl_ack_stage.sv
// Registers masked forced-lock bits into acknowledge bits.
module scl_ack_stage #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] frz,
   input  logic [W-1:0] en,
   output logic [W-1:0] ack
);
   logic [W-1:0] ack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ack_q <= '0;
      else        ack_q <= frz & en;
   end

   assign ack = ack_q;
endmodule

// File: rtl/scl_unit_arb.sv
// Ownership and freeze control for one shared scaler unit.
module scl_unit_arb
   import scl_lock_pkg::*;
#(
   parameter int DPU = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           unit_rst,
   input  logic           enh_req,
   input  logic           enh_frz,
   input  logic [DPU-1:0] dec_req,
   input  logic [DPU-1:0] dec_frz,
   input  logic [DPU-1:0] dec_en,
   output logic           enh_ack,
   output logic           enh_use,
   output logic [DPU-1:0] dec_ack,
   output logic [DPU-1:0] dec_use
);
   localparam int IDX_W = (DPU > 1) ? $clog2(DPU) : 1;

   initial assert (DPU >= 1) else $error("DPU must be at least 1");

   own_kind_e        kind_q;
   logic [IDX_W-1:0] idx_q;
   logic             freeze;
   logic [DPU-1:0]   dec_cand;
   logic [IDX_W-1:0] pick;
   logic             enh_ack_w;

   assign freeze   = enh_frz | (|(dec_frz & dec_en));
   assign dec_cand = dec_req & dec_en;

   // lowest enabled requesting decode instance
   always_comb begin
      pick = '0;
      for (int i = DPU - 1; i >= 0; i--)
         if (dec_cand[i]) pick = IDX_W'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || unit_rst) begin
         kind_q <= OWN_FREE;
         idx_q  <= '0;
      end else if (!freeze) begin
         unique case (kind_q)
            OWN_FREE: begin
               if (enh_req) kind_q <= OWN_ENH;
               else if (|dec_cand) begin
                  kind_q <= OWN_DEC;
                  idx_q  <= pick;
               end
            end
            OWN_ENH: if (!enh_req) kind_q <= OWN_FREE;
            OWN_DEC: if (!dec_cand[idx_q]) kind_q <= OWN_FREE;
            default: kind_q <= OWN_FREE;
         endcase
      end
   end

   scl_ack_stage #(.W(1)) i_enh_ack (
      .clk(clk), .rst_n(rst_n), .frz(enh_frz), .en(1'b1), .ack(enh_ack_w)
   );
   scl_ack_stage #(.W(DPU)) i_dec_ack (
      .clk(clk), .rst_n(rst_n), .frz(dec_frz), .en(dec_en), .ack(dec_ack)
   );

   assign enh_ack = enh_ack_w;
   assign enh_use = enh_ack_w & (kind_q == OWN_ENH);

   for (genvar i = 0; i < DPU; i++) begin : g_use
      assign dec_use[i] = dec_ack[i] & (kind_q == OWN_DEC) & (idx_q == IDX_W'(i));

      assert_ack_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_frz[i] && dec_en[i]) |=> dec_ack[i]);
      assert_ack_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !dec_frz[i] |=> !dec_ack[i]);
      assert_masked_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !dec_en[i] |=> !dec_ack[i]);
      assert_use_needs_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
         dec_use[i] |-> dec_ack[i]);
   end

   assert_held_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !unit_rst) |=> ($stable(kind_q) && $stable(idx_q)));
   assert_free_refuses_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && kind_q == OWN_FREE) |=> kind_q == OWN_FREE);
   assert_unit_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      unit_rst |=> kind_q == OWN_FREE);
   assert_enh_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == OWN_FREE && !freeze && enh_req && !unit_rst) |=> kind_q == OWN_ENH);
   assert_single_user_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({enh_use, dec_use}));
endmodule

// File: rtl/scl_lock_arbiter.sv
// Top: one arbiter per shared scaler unit, decode engines grouped per unit.
module scl_lock_arbiter #(
   parameter int NUM_UNITS    = 2,
   parameter int DEC_PER_UNIT = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_UNITS-1:0]              unit_rst,
   input  logic [NUM_UNITS*DEC_PER_UNIT-1:0] dec_access_mask,
   input  logic [NUM_UNITS*DEC_PER_UNIT-1:0] dec_req,
   input  logic [NUM_UNITS*DEC_PER_UNIT-1:0] dec_force,
   input  logic [NUM_UNITS-1:0]              enh_req,
   input  logic [NUM_UNITS-1:0]              enh_force,
   output logic [NUM_UNITS*DEC_PER_UNIT-1:0] dec_ack,
   output logic [NUM_UNITS*DEC_PER_UNIT-1:0] dec_use,
   output logic [NUM_UNITS-1:0]              enh_ack,
   output logic [NUM_UNITS-1:0]              enh_use
);
   localparam int NUM_DEC = NUM_UNITS * DEC_PER_UNIT;

   initial assert (NUM_UNITS >= 1 && NUM_DEC >= 1)
      else $error("unit and decode counts must be positive");

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      scl_unit_arb #(.DPU(DEC_PER_UNIT)) i_arb (
         .clk      (clk),
         .rst_n    (rst_n),
         .unit_rst (unit_rst[u]),
         .enh_req  (enh_req[u]),
         .enh_frz  (enh_force[u]),
         .dec_req  (dec_req[u*DEC_PER_UNIT +: DEC_PER_UNIT]),
         .dec_frz  (dec_force[u*DEC_PER_UNIT +: DEC_PER_UNIT]),
         .dec_en   (dec_access_mask[u*DEC_PER_UNIT +: DEC_PER_UNIT]),
         .enh_ack  (enh_ack[u]),
         .enh_use  (enh_use[u]),
         .dec_ack  (dec_ack[u*DEC_PER_UNIT +: DEC_PER_UNIT]),
         .dec_use  (dec_use[u*DEC_PER_UNIT +: DEC_PER_UNIT])
      );
   end
endmodule

// File: tb/test_scl_lock_arbiter.sv
module test_scl_lock_arbiter;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] unit_rst;
   logic [3:0] dec_access_mask, dec_req, dec_force, dec_ack, dec_use;
   logic [1:0] enh_req, enh_force, enh_ack, enh_use;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [11:0] q_exp[$];
   string       q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   scl_lock_arbiter i_scl_lock_arbiter (
      .clk(clk), .rst_n(rst_n), .unit_rst(unit_rst),
      .dec_access_mask(dec_access_mask), .dec_req(dec_req), .dec_force(dec_force),
      .enh_req(enh_req), .enh_force(enh_force),
      .dec_ack(dec_ack), .dec_use(dec_use), .enh_ack(enh_ack), .enh_use(enh_use)
   );

   // monitor: compares {enh_use, enh_ack, dec_use, dec_ack}
   always @(negedge clk) begin
      if (q_exp.size() > 0) begin
         logic [11:0] e, a;
         string t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         a = {enh_use, enh_ack, dec_use, dec_ack};
         checks++;
         if (a !== e) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", t, a, e);
         end
      end
   end

   // driver: inputs are set at a negedge, the result is expected after the next posedge
   task automatic step(input logic [1:0] eu, input logic [1:0] ea,
                       input logic [3:0] du, input logic [3:0] da, input string tag);
      @(posedge clk);
      #1;
      q_exp.push_back({eu, ea, du, da});
      q_tag.push_back(tag);
      @(negedge clk);
   endtask

   initial begin
      rst_n = 0; unit_rst = '0; dec_access_mask = 4'b0111;
      dec_req = '0; dec_force = '0; enh_req = '0; enh_force = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      step(2'b00, 2'b00, 4'b0000, 4'b0000, "R1 reset state");
      dec_req[0] = 1;
      step(2'b00, 2'b00, 4'b0000, 4'b0000, "R3 claim no status");
      dec_force[0] = 1;
      step(2'b00, 2'b00, 4'b0001, 4'b0001, "R7 R8 ack and use on owner");
      dec_req[0] = 0; enh_req[0] = 1; dec_req[1] = 1;
      step(2'b00, 2'b00, 4'b0001, 4'b0001, "R5 held unit frozen");
      dec_force[0] = 0;
      step(2'b00, 2'b00, 4'b0000, 4'b0000, "R7 ack drops, R3 release");
      dec_force[1] = 1;
      step(2'b00, 2'b00, 4'b0000, 4'b0010, "R6 free unit refuses claims");
      step(2'b00, 2'b00, 4'b0000, 4'b0010, "R6 still free");
      dec_force[1] = 0;
      step(2'b00, 2'b00, 4'b0000, 4'b0000, "R4 grant after freeze");
      enh_force[0] = 1;
      step(2'b01, 2'b01, 4'b0000, 4'b0000, "R4 enhancement won");
      unit_rst[0] = 1;
      step(2'b00, 2'b01, 4'b0000, 4'b0000, "R10 unit reset clears owner");
      unit_rst[0] = 0;
      step(2'b00, 2'b01, 4'b0000, 4'b0000, "R10 stays free while frozen");
      enh_force[0] = 0; enh_req[0] = 0;
      step(2'b00, 2'b00, 4'b0000, 4'b0000, "R3 regrant to dec1");
      dec_force[1] = 1; dec_force[3] = 1; dec_req[2] = 1;
      step(2'b00, 2'b00, 4'b0010, 4'b0010, "R9 masked force ignored, R2 dec1 on unit0");
      enh_force[1] = 1; dec_force[2] = 1;
      step(2'b00, 2'b10, 4'b0110, 4'b0110, "R2 dec2 owns unit1, R8 enh1 not user");
      dec_force = '0; enh_force = '0; dec_req = '0; enh_req = '0;
      step(2'b00, 2'b00, 4'b0000, 4'b0000, "R7 all acks drop");
      dec_req[3] = 1;
      step(2'b00, 2'b00, 4'b0000, 4'b0000, "R9 masked request");
      dec_force[2] = 1;
      step(2'b00, 2'b00, 4'b0000, 4'b0100, "R9 masked engine never granted");
      repeat (2) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule